// File: doc/BRIEF.md
# Multi-Mode Digital Noise Generator

This block turns a clock into a paced stream of signed 12-bit noise samples. The samples go to the summing path of a DAC, where they are added to control pulses so that calibration loops and optimisers can be tested under controlled disturbance. A mode input selects the noise source. Broadband mode draws samples from a long pseudo-random register. Table mode plays a host-loaded 1024-entry waveform, such as a 1/f-shaped record, from on-chip RAM. Burst mode keeps the output at zero and now and then emits a full-scale glitch of random sign that lasts several samples.

Every sample passes through an 8-bit amplitude multiplier, so the noise level is set apart from the signal it disturbs. The result saturates at the 12-bit limits and never wraps. A programmable divider sets the sample rate. Each new sample comes with a one-cycle valid strobe. The seed is taken while reset is held, so two runs with the same seed and the same settings produce the same sample stream.

Top module: `noise_gen`

## Requirements
- R1: In mode 0 (broadband), the raw sample is the low 12 bits of a 32-bit Galois LFSR. The LFSR shifts right and XORs in mask 0x80200003 when the bit shifted out is 1. It steps once per sample, and each sample uses the state from before that step. The LFSR loads `seed` while reset is held.
- R2: A zero seed is never used. A zero 32-bit seed is replaced by 0x9E3779B9. A zero low half of the seed (which seeds the 16-bit burst LFSR) is replaced by 0xACE1.
- R3: The output is the raw sample times `amp`, shifted right arithmetically by 7 and clamped to the range -2048..2047. With this rule, 128 gives unity gain and 0 gives silence.
- R4: In mode 1 (table), the sample is the table entry at a read pointer. The pointer moves forward once per sample and wraps from 1023 to 0. The host writes entries through `tbl_we`, `tbl_waddr` and `tbl_wdata`.
- R5: A new mode value takes effect at the next sample. A sample taken in a mode different from that of the previous sample reads table address 0, and also ends any glitch that is running.
- R6: In mode 2 (burst), the draw is the 16-bit LFSR state, with mask 0xB400 and the same stepping rule. When no glitch is running and the draw is below `burst_thresh`, a glitch starts. It lasts `burst_len` samples (0 counts as 1) at raw level -2048 if draw bit 0 is 1, or +2047 if it is 0. All other burst-mode samples are 0.
- R7: A `burst_thresh` of 0 keeps the burst-mode output at 0 for good.
- R8: `sample_valid` goes high for one cycle in every `rate_div`+1 clock cycles. With `rate_div` of 0 it stays high.
- R9: While reset is held, `sample_out` and `sample_valid` are 0.
- R10: Mode 3 (quiet) produces samples of value 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; seeds are taken while it is low |
| mode | input | 2 | 0 broadband, 1 table, 2 burst, 3 quiet |
| amp | input | 8 | Amplitude multiplier, 128 = unity |
| rate_div | input | 16 | Sample period minus one, in clock cycles |
| burst_thresh | input | 16 | Glitch start threshold for the 16-bit draw |
| burst_len | input | 8 | Glitch length in samples |
| seed | input | 32 | LFSR seed; the low 16 bits seed the burst LFSR |
| tbl_we | input | 1 | Table write enable |
| tbl_waddr | input | 10 | Table write address |
| tbl_wdata | input | 12 | Table write data, two's complement |
| sample_out | output | 12 | Scaled, saturated noise sample |
| sample_valid | output | 1 | One-cycle strobe marking a new sample |

## Verification
Some properties are checked on every cycle. Both LFSR states never reach zero. Strobes are never closer than the divider allows, and each strobe follows a divider tick by the pipeline depth. Burst mode produces only zero or full-scale raw values. Quiet mode emits zeros. A table read that follows a mode change restarts at address 0. Only the bench scenarios can show the exact values of the sample stream: the LFSR sequences, table order and wrap, the gain and clamp arithmetic, glitch length and sign, and the substitution of a zero seed. The bench compares every sample against a model built from the requirements.

// File: rtl/nz_pkg.sv
// Shared definitions for the noise generator: the mode encoding and the
// LFSR feedback masks and substitute seeds.
package nz_pkg;
    typedef enum logic [1:0] {
        NZ_WHITE = 2'd0,
        NZ_TABLE = 2'd1,
        NZ_BURST = 2'd2,
        NZ_QUIET = 2'd3
    } nz_mode_e;

    localparam logic [31:0] NZ_MASK32 = 32'h8020_0003;
    localparam logic [31:0] NZ_DFLT32 = 32'h9E37_79B9;
    localparam logic [15:0] NZ_MASK16 = 16'hB400;
    localparam logic [15:0] NZ_DFLT16 = 16'hACE1;
endpackage

// File: rtl/nz_rate_div.sv
// Sample-rate clock enable. Raises tick once every DIV+1 cycles.
// Assumes: div may change at any time; a cycle count at or above the new
// value ends the period at once.
module nz_rate_div #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = (cnt >= div);

    // Count cycles inside the current sample period.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + DIV_W'(1);
    end

    // R8
    tick_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div != '0) |=> (!tick || div == '0));
endmodule

// File: rtl/nz_lfsr.sv
// Galois LFSR that shifts right and steps when adv is high.
// Assumes: MASK is a maximal-length polynomial for width W. A zero seed is
// replaced by DFLT, so the state can never lock at zero.
module nz_lfsr #(
    parameter int         W    = 32,
    parameter logic [W-1:0] MASK = '1,
    parameter logic [W-1:0] DFLT = W'(1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] seed,
    input  logic         adv,
    output logic [W-1:0] state
);
    // Load the seed in reset, otherwise step once per advance.
    always_ff @(posedge clk) begin
        if (!rst_n)   state <= (seed == '0) ? DFLT : seed;
        else if (adv) state <= (state >> 1) ^ (state[0] ? MASK : '0);
    end

    // R2
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state != '0);
endmodule

// File: rtl/nz_table_ram.sv
// Single-write, single-read sample RAM with a registered read port, so it
// can map onto block RAM. Assumes: a read and a write to the same address
// in the same cycle return the old data.
module nz_table_ram #(
    parameter int DEPTH = 1024,
    parameter int DW    = 12,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    // Host write port.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/nz_scale_sat.sv
// Combinational gain stage: out = clamp((raw * amp) >>> FRAC).
// Assumes: amp is unsigned; the clamp limits are the signed limits of SW bits.
module nz_scale_sat #(
    parameter int SW   = 12,
    parameter int GW   = 8,
    parameter int FRAC = 7
) (
    input  logic signed [SW-1:0] raw,
    input  logic        [GW-1:0] amp,
    output logic signed [SW-1:0] out
);
    localparam int PW = SW + GW + 1;
    localparam logic signed [PW-1:0] MAXV = PW'((1 << (SW - 1)) - 1);
    localparam logic signed [PW-1:0] MINV = ~MAXV;

    logic signed [PW-1:0] raw_x, amp_x, prod, shifted;

    // Widen, multiply, shift and clamp.
    always_comb begin
        raw_x   = PW'(raw);
        amp_x   = PW'({1'b0, amp});
        prod    = raw_x * amp_x;
        shifted = prod >>> FRAC;
        if (shifted > MAXV)      out = MAXV[SW-1:0];
        else if (shifted < MINV) out = MINV[SW-1:0];
        else                     out = shifted[SW-1:0];
    end

    // R3
    sat_sign_chk: assert final (!(raw >= 0 && out < 0));
endmodule

// File: rtl/noise_gen.sv
// Multi-mode noise sample generator. A divider tick takes one sample from the
// selected source (LFSR, RAM table, burst glitch, or silence). One register
// stage later it is scaled and saturated, and it leaves with a one-cycle
// valid. Assumes: rate_div >= 2 if the mode or gain changes at run time, so
// each change settles between ticks; the table depth is at least 2.
module noise_gen #(
    parameter int SAMPLE_W  = 12,
    parameter int AMP_W     = 8,
    parameter int AMP_FRAC  = 7,
    parameter int TBL_DEPTH = 1024,
    parameter int DIV_W     = 16,
    parameter int BLEN_W    = 8,
    localparam int TBL_AW   = $clog2(TBL_DEPTH)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [1:0]                 mode,
    input  logic [AMP_W-1:0]           amp,
    input  logic [DIV_W-1:0]           rate_div,
    input  logic [15:0]                burst_thresh,
    input  logic [BLEN_W-1:0]          burst_len,
    input  logic [31:0]                seed,
    input  logic                       tbl_we,
    input  logic [TBL_AW-1:0]          tbl_waddr,
    input  logic [SAMPLE_W-1:0]        tbl_wdata,
    output logic signed [SAMPLE_W-1:0] sample_out,
    output logic                       sample_valid
);
    import nz_pkg::*;

    localparam logic signed [SAMPLE_W-1:0] FS_POS = SAMPLE_W'((1 << (SAMPLE_W - 1)) - 1);
    localparam logic signed [SAMPLE_W-1:0] FS_NEG = ~FS_POS;

    nz_mode_e mode_in, mode_prev, s1_mode;
    logic tick, mode_chg, s1_vld;
    logic [31:0] l32;
    logic [15:0] l16;
    logic [TBL_AW-1:0] ptr, rd_addr;
    logic [SAMPLE_W-1:0] tbl_rd;
    logic [BLEN_W-1:0] rem, rem_base, rem_n;
    logic bsign, bsign_n;
    logic signed [SAMPLE_W-1:0] b_raw, s1_white, s1_burst, raw_sel, scaled;

    assign mode_in  = nz_mode_e'(mode);
    assign mode_chg = (mode_in != mode_prev);
    assign rd_addr  = mode_chg ? '0 : ptr;

    nz_rate_div #(.DIV_W(DIV_W)) i_div (
        .clk(clk), .rst_n(rst_n), .div(rate_div), .tick(tick));

    nz_lfsr #(.W(32), .MASK(NZ_MASK32), .DFLT(NZ_DFLT32)) i_lfsr_w (
        .clk(clk), .rst_n(rst_n), .seed(seed), .adv(tick), .state(l32));

    nz_lfsr #(.W(16), .MASK(NZ_MASK16), .DFLT(NZ_DFLT16)) i_lfsr_b (
        .clk(clk), .rst_n(rst_n), .seed(seed[15:0]), .adv(tick), .state(l16));

    nz_table_ram #(.DEPTH(TBL_DEPTH), .DW(SAMPLE_W)) i_ram (
        .clk(clk), .we(tbl_we), .waddr(tbl_waddr), .wdata(tbl_wdata),
        .re(tick), .raddr(rd_addr), .rdata(tbl_rd));

    // Track the mode of the last sample and advance the wrapping read pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr       <= '0;
            mode_prev <= NZ_WHITE;
        end else if (tick) begin
            ptr       <= (rd_addr == TBL_AW'(TBL_DEPTH - 1)) ? '0 : rd_addr + TBL_AW'(1);
            mode_prev <= mode_in;
        end
    end

    // Burst decision: continue a running glitch, start a new one, or stay quiet.
    always_comb begin
        rem_base = mode_chg ? '0 : rem;
        b_raw    = '0;
        rem_n    = rem_base;
        bsign_n  = bsign;
        if (rem_base != '0) begin
            b_raw = bsign ? FS_NEG : FS_POS;
            rem_n = rem_base - BLEN_W'(1);
        end else if (l16 < burst_thresh) begin
            bsign_n = l16[0];
            b_raw   = l16[0] ? FS_NEG : FS_POS;
            rem_n   = (burst_len == '0) ? '0 : burst_len - BLEN_W'(1);
        end
    end

    // Glitch state updates only on burst-mode ticks and clears in other modes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem   <= '0;
            bsign <= 1'b0;
        end else if (tick) begin
            rem   <= (mode_in == NZ_BURST) ? rem_n : '0;
            bsign <= bsign_n;
        end
    end

    // First pipeline stage: capture the sources as they stand at the tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld   <= 1'b0;
            s1_mode  <= NZ_WHITE;
            s1_white <= '0;
            s1_burst <= '0;
        end else begin
            s1_vld <= tick;
            if (tick) begin
                s1_mode  <= mode_in;
                s1_white <= l32[SAMPLE_W-1:0];
                s1_burst <= b_raw;
            end
        end
    end

    // Pick the raw sample of the captured mode.
    always_comb begin
        case (s1_mode)
            NZ_WHITE: raw_sel = s1_white;
            NZ_TABLE: raw_sel = tbl_rd;
            NZ_BURST: raw_sel = s1_burst;
            default:  raw_sel = '0;
        endcase
    end

    nz_scale_sat #(.SW(SAMPLE_W), .GW(AMP_W), .FRAC(AMP_FRAC)) i_scale (
        .raw(raw_sel), .amp(amp), .out(scaled));

    // Output register and valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_out   <= '0;
            sample_valid <= 1'b0;
        end else begin
            sample_valid <= s1_vld;
            if (s1_vld) sample_out <= scaled;
        end
    end

    // R8
    valid_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |-> $past(tick, 2));

    // R6
    burst_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_vld && s1_mode == NZ_BURST) |->
        (s1_burst == FS_POS || s1_burst == FS_NEG || s1_burst == '0));

    // R10
    quiet_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_vld && s1_mode == NZ_QUIET) |=> (sample_out == '0));

    // R5
    table_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mode_in == NZ_TABLE && mode_prev != NZ_TABLE) |=> (ptr == TBL_AW'(1)));
endmodule

// File: tb/test_noise_gen.sv
`timescale 1ns/1ps
// Directed bench for noise_gen. Each scenario task drives the block and
// compares every sample with a model built from the requirements.
module test_noise_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [7:0]  amp = 8'd128;
    logic [15:0] rate_div = 16'd3;
    logic [15:0] thr = 16'd0;
    logic [7:0]  blen = 8'd1;
    logic [31:0] seed = 32'h1;
    logic        tbl_we = 1'b0;
    logic [9:0]  tbl_waddr = '0;
    logic [11:0] tbl_wdata = '0;
    logic signed [11:0] sample_out;
    logic        sample_valid;

    int checks = 0;
    int failures = 0;

    // model state
    logic [31:0] m32;
    logic [15:0] m16;
    int          mptr;
    logic [1:0]  mprev;
    int          mrem;
    logic        msign;
    logic [11:0] tbl_m [1024];

    always #4 clk = ~clk;

    noise_gen i_noise_gen (
        .clk(clk), .rst_n(rst_n), .mode(mode), .amp(amp), .rate_div(rate_div),
        .burst_thresh(thr), .burst_len(blen), .seed(seed), .tbl_we(tbl_we),
        .tbl_waddr(tbl_waddr), .tbl_wdata(tbl_wdata),
        .sample_out(sample_out), .sample_valid(sample_valid));

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] nx32(logic [31:0] s);
        return (s >> 1) ^ (s[0] ? 32'h8020_0003 : 32'h0);
    endfunction

    function automatic logic [15:0] nx16(logic [15:0] s);
        return (s >> 1) ^ (s[0] ? 16'hB400 : 16'h0);
    endfunction

    task automatic model_reset();
        m32   = (seed == 32'h0) ? 32'h9E37_79B9 : seed;
        m16   = (seed[15:0] == 16'h0) ? 16'hACE1 : seed[15:0];
        mptr  = 0;
        mprev = 2'd0;
        mrem  = 0;
        msign = 1'b0;
    endtask

    // Expected value of the next sample, from R1..R10.
    task automatic model_step(output int e);
        logic signed [11:0] raw;
        int addr, p, q;
        logic chg;
        chg   = (mode != mprev);
        addr  = chg ? 0 : mptr;
        mptr  = (addr == 1023) ? 0 : addr + 1;
        mprev = mode;
        if (chg || mode != 2'd2) mrem = 0;
        raw = '0;
        case (mode)
            2'd0: raw = m32[11:0];
            2'd1: raw = tbl_m[addr];
            2'd2: begin
                if (mrem != 0) begin
                    raw = msign ? 12'h800 : 12'h7FF;
                    mrem--;
                end else if (m16 < thr) begin
                    msign = m16[0];
                    raw   = msign ? 12'h800 : 12'h7FF;
                    mrem  = (blen == 0) ? 0 : int'(blen) - 1;
                end
            end
            default: raw = '0;
        endcase
        m32 = nx32(m32);
        m16 = nx16(m16);
        p = int'(raw) * int'(amp);
        q = p >>> 7;
        if (q > 2047) q = 2047;
        if (q < -2048) q = -2048;
        e = q;
    endtask

    task automatic get_sample(output int v);
        do @(negedge clk); while (!sample_valid);
        v = int'(sample_out);
    endtask

    task automatic do_reset(logic [31:0] s, logic [15:0] div, logic [1:0] md);
        @(negedge clk);
        rst_n = 1'b0;
        seed = s;
        rate_div = div;
        mode = md;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic run_cmp(int n, string req);
        int v, e;
        for (int i = 0; i < n; i++) begin
            get_sample(v);
            model_step(e);
            check(req, v, e);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 out", int'(sample_out), 0);
        check("R9 valid", int'(sample_valid), 0);
    endtask

    task automatic t_rate(logic [15:0] div);
        int v, n;
        do_reset(32'h1, div, 2'd0);
        get_sample(v);
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 1 && div != 0) check("R8 pulse width", int'(sample_valid), 0);
        end while (!sample_valid);
        check("R8 period", n, int'(div) + 1);
    endtask

    task automatic t_white();
        do_reset(32'hDEAD_BEEF, 16'd3, 2'd0);
        amp = 8'd128;
        run_cmp(20, "R1");
        amp = 8'd255;
        run_cmp(20, "R3 gain");
        amp = 8'd0;
        run_cmp(10, "R3 zero");
        amp = 8'd37;
        run_cmp(10, "R3 frac");
        amp = 8'd128;
    endtask

    task automatic t_zero_seed();
        do_reset(32'h0, 16'd3, 2'd0);
        run_cmp(12, "R2");
        do_reset(32'h1234_0000, 16'd3, 2'd2);
        thr = 16'h4000;
        blen = 8'd2;
        run_cmp(40, "R2 burst");
    endtask

    task automatic t_table();
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 1024; i++) begin
            tbl_m[i] = 12'(i * 37 + 5);
            tbl_we = 1'b1;
            tbl_waddr = 10'(i);
            tbl_wdata = tbl_m[i];
            @(negedge clk);
        end
        tbl_we = 1'b0;
        do_reset(32'h55, 16'd3, 2'd1);
        run_cmp(1030, "R4");
    endtask

    task automatic t_switch();
        int v, e;
        do_reset(32'h77, 16'd3, 2'd1);
        run_cmp(5, "R4 pre");
        mode = 2'd0;
        run_cmp(3, "R5 to white");
        mode = 2'd1;
        get_sample(v);
        model_step(e);
        check("R5 restart", v, int'($signed(tbl_m[0])));
        run_cmp(4, "R5 after");
    endtask

    task automatic t_burst();
        do_reset(32'hC0FF_EE11, 16'd3, 2'd2);
        thr = 16'h3000;
        blen = 8'd3;
        amp = 8'd128;
        run_cmp(200, "R6");
        blen = 8'd0;
        amp = 8'd64;
        run_cmp(80, "R6 len0");
        amp = 8'd128;
    endtask

    task automatic t_burst_off();
        do_reset(32'hABCD_1234, 16'd3, 2'd2);
        thr = 16'h0;
        blen = 8'd5;
        amp = 8'd255;
        for (int i = 0; i < 100; i++) begin
            int v, e;
            get_sample(v);
            model_step(e);
            check("R7", v, 0);
        end
        amp = 8'd128;
    endtask

    task automatic t_quiet();
        do_reset(32'h42, 16'd3, 2'd3);
        amp = 8'd255;
        for (int i = 0; i < 30; i++) begin
            int v, e;
            get_sample(v);
            model_step(e);
            check("R10", v, 0);
        end
        amp = 8'd128;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        t_reset();
        t_rate(16'd5);
        t_rate(16'd0);
        t_white();
        t_zero_seed();
        t_table();
        t_switch();
        t_burst();
        t_burst_off();
        t_quiet();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end
endmodule